// File: doc/BRIEF.md
# Battery-Backed Static RAM Access Controller

This block is the bus-side control of a byte-wide static RAM that keeps its contents on battery. An external agent drives active-low chip-enable, write-enable and output-enable strobes, a 15-bit address and a byte of write data. The block turns these strobes into read and write cycles on an internal register array. The strobes are sampled on the system clock. The bidirectional data bus is split into a data-in port, a data-out port and a drive-enable output, so the design stays synthesizable.

A digital power-good input gates every access. While it is low, nothing is read or written. When power returns, the block latches the two battery status inputs. If both report a low battery, the block suppresses the second memory cycle after power-up. Software can then find out about possible data loss by writing a location and reading it back. After each write, write-enable must stay high for a recovery interval of `REC_CYC` clock edges. A cycle that starts inside this interval raises a one-cycle violation flag, and the cycle itself still runs.

Top module: `bbsram_ctrl`

## Requirements
- R1: When power-good is high, chip-enable low, write-enable high and output-enable low at a clock edge, `dout_en` is 1 after that edge and `dout` holds the stored byte at the sampled address, unless R7 inhibits the cycle.
- R2: At any edge where chip-enable is high, write-enable is low or output-enable is high, `dout_en` is 0 after that edge. This includes write-enable falling while the outputs are driving.
- R3: The write window is open at each edge where chip-enable and write-enable are both low. The byte written is the address and data sampled at the last edge with the window open. It is stored at the first edge where the window is closed, whichever strobe rose, and a read at any later edge returns it.
- R4: The address is 15 bits and data is 8 bits. Only the low `MEM_AW` address bits (8 by default) select a byte, so addresses that differ only above bit `MEM_AW-1` reach the same byte.
- R5: At an edge where power-good is low, `dout_en` is 0 after the edge and no byte is stored. A write window that is open when power fails is dropped.
- R6: At the power-up edge (the first edge with power-good high after reset or after an edge with power-good low), the battery is judged low only if `batt_low_a` and `batt_low_b` are both 1.
- R7: After a power-up with the battery judged low, the second cycle start neither drives `dout_en` nor stores a byte. The first cycle start and every start after the second are unaffected.
- R8: A cycle start is an edge, with power-good high, at which chip-enable is low after being high at the previous edge. Write-enable falling while chip-enable stays low is also a start. Both strobes falling at the same edge count as one start.
- R9: A cycle start at any of the `REC_CYC` edges that follow the edge where a write window closed sets `rec_viol` to 1 for exactly one cycle. A later start leaves it at 0, and the flagged cycle still performs its access.
- R10: During and right after reset, `dout_en`, `dout` and `rec_viol` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the strobes are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_good | input | 1 | High while the supply is in range |
| batt_low_a | input | 1 | First battery below its threshold |
| batt_low_b | input | 1 | Second battery below its threshold |
| cs_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | 15 | Byte address |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data toward the bus |
| dout_en | output | 1 | High when the block drives the data bus |
| rec_viol | output | 1 | One-cycle pulse: a cycle started inside the write recovery interval |

## Verification
Two decisions can fall on the same clock edge: detecting a cycle start and applying the low-battery inhibit. The bench provokes this by powering up with both batteries low, opening a read, and then dropping write-enable while chip-enable stays low. That drop is the second start, so the write opened there must not be stored, and a later read must return the old byte. A second case drops both strobes together to show that a simultaneous fall counts as one start. A third case issues a read inside the recovery interval and checks two things at once: the flag pulses for one cycle, and the read data is still correct.

// File: rtl/bbsram_pkg.sv
`timescale 1ns/1ps
package bbsram_pkg;

    typedef enum logic [1:0] {
        CYC_NONE   = 2'd0,
        CYC_FIRST  = 2'd1,
        CYC_SECOND = 2'd2,
        CYC_LATER  = 2'd3
    } cyc_idx_e;

    function automatic cyc_idx_e cyc_advance(input cyc_idx_e cur);
        case (cur)
            CYC_NONE:   return CYC_FIRST;
            CYC_FIRST:  return CYC_SECOND;
            default:    return CYC_LATER;
        endcase
    endfunction

endpackage

// File: rtl/bbsram_strobe_dec.sv
`timescale 1ns/1ps
module bbsram_strobe_dec #(
    parameter int CAP_W  = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [CAP_W-1:0]  addr,
    input  logic [DATA_W-1:0] din,
    output logic              start,
    output logic              pwr_up,
    output logic              wr_close,
    output logic [CAP_W-1:0]  wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        logic              prev_cs_n;
        logic              prev_we_n;
        logic              prev_pg;
        logic              wr_open;
        logic [CAP_W-1:0]  wr_addr;
        logic [DATA_W-1:0] wr_data;
    } dec_t;

    dec_t dec_d, dec_q;
    logic win_now;

    always_comb begin
        win_now  = pwr_good & ~cs_n & ~we_n;
        start    = pwr_good & ~cs_n & (dec_q.prev_cs_n | (dec_q.prev_we_n & ~we_n));
        pwr_up   = pwr_good & ~dec_q.prev_pg;
        wr_close = dec_q.wr_open & ~win_now & pwr_good;
        wr_addr  = dec_q.wr_addr;
        wr_data  = dec_q.wr_data;

        dec_d           = dec_q;
        dec_d.prev_cs_n = cs_n;
        dec_d.prev_we_n = we_n;
        dec_d.prev_pg   = pwr_good;
        dec_d.wr_open   = win_now;
        if (win_now) begin
            dec_d.wr_addr = addr;
            dec_d.wr_data = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_q <= '{prev_cs_n: 1'b1, prev_we_n: 1'b1, prev_pg: 1'b0,
                       wr_open: 1'b0, wr_addr: '0, wr_data: '0};
        end else begin
            dec_q <= dec_d;
        end
    end

endmodule

// File: rtl/bbsram_guard.sv
`timescale 1ns/1ps
module bbsram_guard
    import bbsram_pkg::*;
#(
    parameter int REC_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_up,
    input  logic start,
    input  logic wr_close,
    input  logic batt_low_a,
    input  logic batt_low_b,
    output logic inhibit,
    output logic rec_viol
);

    localparam int RC_W = (REC_CYC < 1) ? 1 : $clog2(REC_CYC + 1);
    localparam logic [RC_W-1:0] RC_LOAD = RC_W'(REC_CYC);

    typedef struct packed {
        logic            batt_bad;
        cyc_idx_e        idx;
        logic            inh;
        logic [RC_W-1:0] rec_cnt;
        logic            viol;
    } guard_t;

    guard_t g_d, g_q;
    logic     bb;
    cyc_idx_e base_idx;
    logic     base_inh;

    always_comb begin
        bb       = pwr_up ? (batt_low_a & batt_low_b) : g_q.batt_bad;
        base_idx = pwr_up ? CYC_NONE : g_q.idx;
        base_inh = pwr_up ? 1'b0 : g_q.inh;

        g_d          = g_q;
        g_d.batt_bad = bb;
        if (start) begin
            g_d.idx = cyc_advance(base_idx);
            g_d.inh = bb & (cyc_advance(base_idx) == CYC_SECOND);
        end else begin
            g_d.idx = base_idx;
            g_d.inh = base_inh;
        end
        inhibit = g_d.inh;

        g_d.viol = start & (g_q.rec_cnt != '0);
        if (wr_close) begin
            g_d.rec_cnt = RC_LOAD;
        end else if (g_q.rec_cnt != '0) begin
            g_d.rec_cnt = g_q.rec_cnt - 1'b1;
        end
        rec_viol = g_q.viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            g_q <= '{batt_bad: 1'b0, idx: CYC_NONE, inh: 1'b0, rec_cnt: '0, viol: 1'b0};
        end else begin
            g_q <= g_d;
        end
    end

endmodule

// File: rtl/bbsram_store.sv
`timescale 1ns/1ps
module bbsram_store #(
    parameter int MEM_AW = 8,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    localparam int DEPTH = 1 << MEM_AW;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } rd_t;

    logic [DATA_W-1:0] mem [DEPTH];
    rd_t rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = rd_en ? mem[rd_addr] : '0;
        rd_data    = rd_q.data;
        rd_valid   = rd_q.valid;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{valid: 1'b0, data: '0};
        end else begin
            rd_q <= rd_d;
        end
    end

endmodule

// File: rtl/bbsram_ctrl.sv
`timescale 1ns/1ps
module bbsram_ctrl #(
    parameter int ADDR_W  = 15,
    parameter int DATA_W  = 8,
    parameter int MEM_AW  = 8,
    parameter int REC_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic              batt_low_a,
    input  logic              batt_low_b,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic              rec_viol
);

    localparam int CAP_W = (MEM_AW < ADDR_W) ? MEM_AW : ADDR_W;

    logic              start;
    logic              pwr_up;
    logic              wr_close;
    logic [CAP_W-1:0]  wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              inhibit;
    logic              mem_we;
    logic              rd_en;
    logic [CAP_W-1:0]  sel_addr;

    assign sel_addr = addr[CAP_W-1:0];

    generate
        if (CAP_W < ADDR_W) begin : g_alias
            logic unused_hi_addr;
            assign unused_hi_addr = ^addr[ADDR_W-1:CAP_W];
        end
    endgenerate

    bbsram_strobe_dec #(
        .CAP_W  (CAP_W),
        .DATA_W (DATA_W)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .cs_n     (cs_n),
        .we_n     (we_n),
        .addr     (sel_addr),
        .din      (din),
        .start    (start),
        .pwr_up   (pwr_up),
        .wr_close (wr_close),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    bbsram_guard #(
        .REC_CYC (REC_CYC)
    ) u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_up     (pwr_up),
        .start      (start),
        .wr_close   (wr_close),
        .batt_low_a (batt_low_a),
        .batt_low_b (batt_low_b),
        .inhibit    (inhibit),
        .rec_viol   (rec_viol)
    );

    assign mem_we = wr_close & ~inhibit;
    assign rd_en  = pwr_good & ~cs_n & we_n & ~oe_n & ~inhibit;

    bbsram_store #(
        .MEM_AW (CAP_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mem_we),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_en    (rd_en),
        .rd_addr  (sel_addr),
        .rd_data  (dout),
        .rd_valid (dout_en)
    );

endmodule

// File: rtl/bbsram_ctrl_chk.sv
`timescale 1ns/1ps
module bbsram_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic cs_n,
    input logic we_n,
    input logic oe_n,
    input logic dout_en,
    input logic rec_viol,
    input logic mem_we
);

    assert_drive_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || !we_n || oe_n) |=> !dout_en);

    assert_pwr_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!dout_en && !rec_viol));

    assert_store_pwr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> pwr_good);

    assert_store_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(!cs_n && !we_n));

    assert_viol_needs_select_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !rec_viol);

endmodule

bind bbsram_ctrl bbsram_ctrl_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .cs_n     (cs_n),
    .we_n     (we_n),
    .oe_n     (oe_n),
    .dout_en  (dout_en),
    .rec_viol (rec_viol),
    .mem_we   (mem_we)
);

// File: tb/sim_bbsram_ctrl.sv
`timescale 1ns/1ps
module sim_bbsram_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        pwr_good;
    logic        batt_low_a;
    logic        batt_low_b;
    logic        cs_n;
    logic        we_n;
    logic        oe_n;
    logic [14:0] addr;
    logic [7:0]  din;
    logic [7:0]  dout;
    logic        dout_en;
    logic        rec_viol;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    bbsram_ctrl #(.REC_CYC(3)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .batt_low_a (batt_low_a),
        .batt_low_b (batt_low_b),
        .cs_n       (cs_n),
        .we_n       (we_n),
        .oe_n       (oe_n),
        .addr       (addr),
        .din        (din),
        .dout       (dout),
        .dout_en    (dout_en),
        .rec_viol   (rec_viol)
    );

    // row: {cs_n, we_n, oe_n, addr[14:0], din[7:0], exp_en, exp_dout[7:0]}
    localparam logic [34:0] VEC [21] = '{
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00},
        {3'b001, 15'h0005, 8'hA5, 1'b0, 8'h00},  // R3 window opens
        {3'b111, 15'h0005, 8'hA5, 1'b0, 8'h00},  // R3 closed by both
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00},
        {3'b010, 15'h0005, 8'h00, 1'b1, 8'hA5},  // R1 read back
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00},  // R2
        {3'b001, 15'h0105, 8'h3C, 1'b0, 8'h00},  // R4 alias write
        {3'b011, 15'h0105, 8'h00, 1'b0, 8'h00},  // R3 closed by we, oe high
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00},
        {3'b010, 15'h0005, 8'h00, 1'b1, 8'h3C},  // R4 alias read
        {3'b010, 15'h0205, 8'h00, 1'b1, 8'h3C},  // R4 another alias
        {3'b000, 15'h0007, 8'h11, 1'b0, 8'h00},  // R2 we falls while driving
        {3'b100, 15'h0007, 8'hFF, 1'b0, 8'h00},  // R3 closed by cs
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00},
        {3'b010, 15'h0007, 8'h00, 1'b1, 8'h11},  // R3 last sampled data
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00},
        {3'b001, 15'h0009, 8'h01, 1'b0, 8'h00},
        {3'b001, 15'h0009, 8'h02, 1'b0, 8'h00},
        {3'b111, 15'h0009, 8'h03, 1'b0, 8'h00},
        {3'b010, 15'h0009, 8'h00, 1'b1, 8'h02},  // R3 final open edge wins
        {3'b111, 15'h0000, 8'h00, 1'b0, 8'h00}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // apply inputs (called at a negedge), then advance to the next negedge
    task automatic cyc(input logic c, input logic w, input logic o,
                       input logic [14:0] a, input logic [7:0] d);
        cs_n = c; we_n = w; oe_n = o; addr = a; din = d;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b1, 15'h0, 8'h0);
    endtask

    task automatic do_write(input logic [14:0] a, input logic [7:0] d);
        cyc(1'b0, 1'b0, 1'b1, a, d);
        cyc(1'b1, 1'b1, 1'b1, a, d);
    endtask

    task automatic do_read(input string req, input logic [14:0] a,
                           input logic en, input logic [7:0] d);
        cyc(1'b0, 1'b1, 1'b0, a, 8'h0);
        check(req, "dout_en", 32'(dout_en), 32'(en));
        if (en) check(req, "dout", 32'(dout), 32'(d));
        cyc(1'b1, 1'b1, 1'b1, 15'h0, 8'h0);
    endtask

    task automatic power_cycle(input logic ba, input logic bb);
        pwr_good = 1'b0;
        idle(2);
        batt_low_a = ba;
        batt_low_b = bb;
        pwr_good = 1'b1;
        idle(2);
    endtask

    initial begin
        rst_n = 1'b0; pwr_good = 1'b1; batt_low_a = 1'b0; batt_low_b = 1'b0;
        cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0; din = '0;
        repeat (3) @(negedge clk);
        // R10: outputs quiet in reset
        check("R10", "dout_en in reset", 32'(dout_en), 32'd0);
        check("R10", "rec_viol in reset", 32'(rec_viol), 32'd0);
        rst_n = 1'b1;
        idle(1);
        check("R10", "dout after reset", 32'(dout), 32'd0);
        check("R10", "dout_en after reset", 32'(dout_en), 32'd0);

        // table walk: R1 R2 R3 R4
        for (int r = 0; r < 21; r++) begin
            cyc(VEC[r][34], VEC[r][33], VEC[r][32], VEC[r][31:17], VEC[r][16:9]);
            check("R1/R2/R3/R4 table", "dout_en", 32'(dout_en), 32'(VEC[r][8]));
            if (VEC[r][8]) check("R1/R3/R4 table", "dout", 32'(dout), 32'(VEC[r][7:0]));
        end
        idle(5);

        // R9: start at third edge after close -> flagged, access still done
        do_write(15'h0020, 8'h77);
        idle(2);
        cyc(1'b0, 1'b1, 1'b0, 15'h0020, 8'h0);
        check("R9", "rec_viol early start", 32'(rec_viol), 32'd1);
        check("R9", "dout_en early start", 32'(dout_en), 32'd1);
        check("R9", "dout early start", 32'(dout), 32'h77);
        cyc(1'b1, 1'b1, 1'b1, 15'h0, 8'h0);
        check("R9", "rec_viol one cycle", 32'(rec_viol), 32'd0);
        idle(5);
        do_write(15'h0021, 8'h78);
        idle(3);
        cyc(1'b0, 1'b1, 1'b0, 15'h0021, 8'h0);
        check("R9", "rec_viol late start", 32'(rec_viol), 32'd0);
        check("R9", "dout late start", 32'(dout), 32'h78);
        idle(5);

        // R5: power-down blocks everything
        do_write(15'h0030, 8'h66);
        do_write(15'h0031, 8'h55);
        idle(5);
        pwr_good = 1'b0;
        idle(1);
        do_read("R5", 15'h0030, 1'b0, 8'h00);
        do_write(15'h0030, 8'h99);
        pwr_good = 1'b1;
        idle(2);
        cyc(1'b0, 1'b0, 1'b1, 15'h0031, 8'h42);
        pwr_good = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 15'h0031, 8'h42);
        cyc(1'b1, 1'b1, 1'b1, 15'h0031, 8'h42);
        pwr_good = 1'b1;
        idle(2);
        do_read("R5", 15'h0030, 1'b1, 8'h66);
        do_read("R5", 15'h0031, 1'b1, 8'h55);

        // preload for battery tests
        idle(5);
        do_write(15'h0040, 8'h10);
        idle(5);
        do_write(15'h0041, 8'h00);
        idle(5);

        // R7 R8: both low; we falling under held cs is the second start
        power_cycle(1'b1, 1'b1);
        cyc(1'b0, 1'b1, 1'b0, 15'h0040, 8'h00);
        check("R7", "first cycle drives", 32'(dout_en), 32'd1);
        check("R7", "first cycle data", 32'(dout), 32'h10);
        cyc(1'b0, 1'b0, 1'b1, 15'h0040, 8'hEE);
        cyc(1'b0, 1'b1, 1'b1, 15'h0040, 8'hEE);
        cyc(1'b1, 1'b1, 1'b1, 15'h0000, 8'h00);
        idle(5);
        do_read("R8", 15'h0040, 1'b1, 8'h10);

        // R7 R8: simultaneous fall counts once; second cycle read blocked
        power_cycle(1'b1, 1'b1);
        do_write(15'h0041, 8'h21);
        idle(5);
        do_read("R7", 15'h0041, 1'b0, 8'h00);
        do_read("R8", 15'h0041, 1'b1, 8'h21);

        // R6: one battery low only -> no inhibit
        power_cycle(1'b1, 1'b0);
        do_read("R6", 15'h0041, 1'b1, 8'h21);
        do_write(15'h0042, 8'h5A);
        idle(5);
        do_read("R6", 15'h0042, 1'b1, 8'h5A);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule